// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream a memory controller sends to an SDRAM device and keeps, for every bank, whether a row is open and whether the bank is still waiting out its precharge time. For each incoming command it gives a combinational verdict on whether that command is legal given the present bank state. A controller or protocol monitor can use the verdict to hold back a command, or to flag one.

Only legal commands change the tracked state. The block follows one burst at a time, which is the most recent legal READ or WRITE. Through that burst it tracks three things: when an auto-precharge fires, how BURST TERMINATE cuts a burst short, and how full-page mode cancels the auto-precharge request. It does not drive device pins, move data or schedule refresh.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every row reads closed, no bank is busy, and no burst is in flight.
- R2: ACTIVE (cmd_code 1) is legal only to a bank whose row is closed and which is not busy. A legal ACTIVE shows the row open from the next cycle.
- R3: READ (cmd_code 2) and WRITE (cmd_code 3) are legal only to a bank whose row is open and which is not busy. Without auto-precharge they leave the row open and the bank idle.
- R4: PRECHARGE (cmd_code 4) is legal to any bank that is not busy. On an open bank issued in cycle c, the row reads closed from c+1 and the bank is busy in cycles c+1 to c+TRP_CYC. On a closed bank it has no effect.
- R5: A READ or WRITE with cmd_ap=1 in cycle c, with burst length N = 2^burst_code and burst_full=0, makes the bank busy from c+1. Its row reads closed from c+N. The bank stays busy through cycle c+N+TRP_CYC and accepts commands again from c+N+TRP_CYC+1.
- R6: With burst_full=1 the cmd_ap flag is ignored: the row stays open and the bank never goes busy from that burst.
- R7: Auto-precharge applies only to the command that carries it. A later READ or WRITE with cmd_ap=0 to the reopened bank leaves it open and idle.
- R8: BURST TERMINATE (cmd_code 5) is legal whenever no auto-precharge burst is in flight, including when no burst exists at all. It never closes a row.
- R9: While an auto-precharge burst is in flight, any READ, WRITE or BURST TERMINATE to any bank is illegal. ACTIVE and PRECHARGE to other banks are still judged normally.
- R10: An illegal command, including the unused codes 6 and 7, changes no row or busy state.
- R11: NOP (cmd_code 0) is always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_code | input | 3 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE |
| cmd_ap | input | 1 | Auto-precharge request carried by READ/WRITE |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| burst_code | input | BL_CODE_W | Fixed burst length is 2^burst_code |
| burst_full | input | 1 | 1 selects full-page bursts |
| row_open | output | NUM_BANKS | Per-bank row-open flags |
| bank_busy | output | NUM_BANKS | Per-bank busy flags (precharge pending or timing) |
| cmd_legal | output | 1 | Verdict for the command presented this cycle |

## Verification
The legality verdict is driven with several kinds of command: commands to closed banks, to open banks and to busy banks, plus undefined codes. These separate a state check that is wrong from a missing busy check. Auto-precharge reads are tried with burst lengths 1 and 4, and every cycle of the window is sampled, so an off-by-one in either the burst count or the precharge count shows up on a specific cycle. Full-page reads that carry the auto-precharge flag, and terminates issued with and without a burst, show whether the flag is dropped and whether the row survives. Probes issued while an auto-precharge burst is in flight show which commands are blocked and which still go through.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_BST = 3'd5;

  // granted (legal) command classes
  typedef struct packed {
    logic act;
    logic rw;
    logic pre;
    logic bst;
  } sbt_go_t;

endpackage

// File: rtl/sbt_reset_sync.sv
module sbt_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot #(
  parameter int TRP_CYC = 3,
  localparam int CNT_W = $clog2(TRP_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_set,
  input  logic pre_start,
  input  logic ap_start,
  output logic open_q,
  output logic cnt_busy
);
  logic             open_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             slot_en;

  always_comb begin
    open_d  = open_q;
    cnt_d   = cnt_q;
    slot_en = act_set | pre_start | ap_start | (cnt_q != '0);
    if (pre_start) begin
      open_d = 1'b0;
      cnt_d  = CNT_W'(TRP_CYC);
    end else if (ap_start) begin
      // one extra cycle stands for the virtual precharge slot after the last beat
      open_d = 1'b0;
      cnt_d  = CNT_W'(TRP_CYC + 1);
    end else begin
      if (act_set) open_d = 1'b1;
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (slot_en) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_busy = (cnt_q != '0);

  p_act_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |-> (!open_q && cnt_q == '0));

  p_ap_only_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |-> open_q);

  p_cnt_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !pre_start && !ap_start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sbt_burst_track.sv
module sbt_burst_track #(
  parameter int BANK_W    = 2,
  parameter int BL_CODE_W = 2,
  localparam int MAX_LEN  = 1 << ((1 << BL_CODE_W) - 1),
  localparam int REM_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BANK_W-1:0]    start_bank,
  input  logic                 start_ap,
  input  logic [BL_CODE_W-1:0] burst_code,
  input  logic                 burst_full,
  input  logic                 stop,
  output logic                 burst_act,
  output logic [BANK_W-1:0]    burst_bank,
  output logic                 ap_inflight,
  output logic                 ap_fire,
  output logic [BANK_W-1:0]    ap_fire_bank
);
  logic              act_q, act_d;
  logic              ap_q, ap_d;
  logic              full_q, full_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              trk_en;
  logic [REM_W:0]    len_oh;
  logic [REM_W:0]    len_m1;

  always_comb begin
    len_oh = {{REM_W{1'b0}}, 1'b1} << burst_code;
    len_m1 = len_oh - 1'b1;
  end

  always_comb begin
    act_d   = act_q;
    ap_d    = ap_q;
    full_d  = full_q;
    bank_d  = bank_q;
    rem_d   = rem_q;
    ap_fire = 1'b0;
    trk_en  = start | stop | (act_q & ~full_q);
    if (start) begin
      bank_d = start_bank;
      full_d = burst_full;
      ap_d   = start_ap & ~burst_full;
      rem_d  = len_m1[REM_W-1:0];
      if (!burst_full && len_m1 == '0) begin
        // single-beat burst ends in its own cycle
        act_d   = 1'b0;
        ap_d    = 1'b0;
        ap_fire = start_ap;
      end else begin
        act_d = 1'b1;
      end
    end else if (stop) begin
      act_d = 1'b0;
      ap_d  = 1'b0;
    end else if (act_q && !full_q) begin
      if (rem_q <= REM_W'(1)) begin
        act_d   = 1'b0;
        ap_d    = 1'b0;
        ap_fire = ap_q;
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      full_q <= 1'b0;
      bank_q <= '0;
      rem_q  <= '0;
    end else if (trk_en) begin
      act_q  <= act_d;
      ap_q   <= ap_d;
      full_q <= full_d;
      bank_q <= bank_d;
      rem_q  <= rem_d;
    end
  end

  assign burst_act    = act_q;
  assign burst_bank   = bank_q;
  assign ap_inflight  = act_q & ap_q;
  assign ap_fire_bank = start ? start_bank : bank_q;

  p_ap_burst_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ap_q) |-> (!start && !stop));

  p_fixed_rem_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> (rem_q != '0));

  p_full_no_ap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && full_q) |-> !ap_q);
endmodule

// File: rtl/sbt_legal_check.sv
module sbt_legal_check
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [2:0]           cmd_code,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [NUM_BANKS-1:0] row_open,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic                 ap_inflight,
  output logic                 cmd_legal,
  output sbt_go_t              go
);
  logic open_b;
  logic busy_b;

  always_comb begin
    open_b    = row_open[cmd_bank];
    busy_b    = bank_busy[cmd_bank];
    cmd_legal = 1'b0;
    go        = '0;
    case (cmd_code)
      OP_NOP: cmd_legal = 1'b1;
      OP_ACT: begin
        cmd_legal = !open_b && !busy_b;
        go.act    = cmd_legal;
      end
      OP_RD, OP_WR: begin
        cmd_legal = open_b && !busy_b && !ap_inflight;
        go.rw     = cmd_legal;
      end
      OP_PRE: begin
        cmd_legal = !busy_b;
        go.pre    = cmd_legal;
      end
      OP_BST: begin
        cmd_legal = !ap_inflight;
        go.bst    = cmd_legal;
      end
      default: cmd_legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP_CYC   = 3,
  parameter int BL_CODE_W = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_code,
  input  logic                 cmd_ap,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [BL_CODE_W-1:0] burst_code,
  input  logic                 burst_full,
  output logic [NUM_BANKS-1:0] row_open,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic                 cmd_legal
);
  logic                 rst_sync_n;
  sbt_go_t              go;
  logic                 burst_act;
  logic [BANK_W-1:0]    burst_bank;
  logic                 ap_inflight;
  logic                 ap_fire;
  logic [BANK_W-1:0]    ap_fire_bank;
  logic                 burst_stop;
  logic [NUM_BANKS-1:0] cnt_busy;

  sbt_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbt_legal_check #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_legal (
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .row_open    (row_open),
    .bank_busy   (bank_busy),
    .ap_inflight (ap_inflight),
    .cmd_legal   (cmd_legal),
    .go          (go)
  );

  // a terminate, or a precharge to the bursting bank, ends the tracked burst
  assign burst_stop = go.bst | (go.pre & burst_act & (cmd_bank == burst_bank));

  sbt_burst_track #(.BANK_W(BANK_W), .BL_CODE_W(BL_CODE_W)) u_burst (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start        (go.rw),
    .start_bank   (cmd_bank),
    .start_ap     (cmd_ap),
    .burst_code   (burst_code),
    .burst_full   (burst_full),
    .stop         (burst_stop),
    .burst_act    (burst_act),
    .burst_bank   (burst_bank),
    .ap_inflight  (ap_inflight),
    .ap_fire      (ap_fire),
    .ap_fire_bank (ap_fire_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(b));

    sbt_bank_slot #(.TRP_CYC(TRP_CYC)) u_slot (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .act_set   (go.act & hit),
      .pre_start (go.pre & hit & row_open[b]),
      .ap_start  (ap_fire & (ap_fire_bank == BANK_W'(b))),
      .open_q    (row_open[b]),
      .cnt_busy  (cnt_busy[b])
    );

    assign bank_busy[b] = cnt_busy[b] | (ap_inflight & (burst_bank == BANK_W'(b)));
  end

  p_illegal_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd_legal && !ap_inflight) |=> $stable(row_open));

  p_bst_keeps_rows_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_legal && cmd_code == OP_BST) |=> $stable(row_open));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_legal && cmd_code == OP_ACT) |=> row_open[$past(cmd_bank)]);

  p_nop_legal_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_code == OP_NOP) |-> cmd_legal);
endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd_code;
  logic       cmd_ap;
  logic [1:0] cmd_bank;
  logic [1:0] burst_code;
  logic       burst_full;
  logic [3:0] row_open;
  logic [3:0] bank_busy;
  logic       cmd_legal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_code   (cmd_code),
    .cmd_ap     (cmd_ap),
    .cmd_bank   (cmd_bank),
    .burst_code (burst_code),
    .burst_full (burst_full),
    .row_open   (row_open),
    .bank_busy  (bank_busy),
    .cmd_legal  (cmd_legal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one command in the low phase; outputs then show this cycle's state
  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic ap,
                      input logic [1:0] code, input logic full);
    @(negedge clk);
    cmd_code = c; cmd_bank = b; cmd_ap = ap; burst_code = code; burst_full = full;
    #1;
  endtask

  task automatic nop();
    step(3'd0, 2'd0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_code = 3'd0; cmd_bank = 2'd0; cmd_ap = 1'b0; burst_code = 2'd0; burst_full = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    nop();
    check("R1 rows closed", row_open, 4'b0000);
    check("R1 banks idle", bank_busy, 4'b0000);
    check("R11 nop legal", cmd_legal, 1'b1);
  endtask

  task automatic t_activate();
    do_reset();
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);
    check("R2 act closed bank", cmd_legal, 1'b1);
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);
    check("R2 act open bank illegal", cmd_legal, 1'b0);
    check("R2 row opened", row_open, 4'b0010);
    nop();
    check("R10 illegal act no effect", row_open, 4'b0010);
    check("R10 illegal act busy", bank_busy, 4'b0000);
  endtask

  task automatic t_rw();
    do_reset();
    step(3'd2, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R3 read closed bank", cmd_legal, 1'b0);
    nop();
    check("R10 illegal read no effect", row_open, 4'b0000);
    step(3'd1, 2'd2, 1'b0, 2'd0, 1'b0);
    step(3'd3, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R3 write open bank", cmd_legal, 1'b1);
    nop();
    check("R3 row stays open", row_open, 4'b0100);
    check("R3 bank idle", bank_busy, 4'b0000);
  endtask

  task automatic t_precharge();
    do_reset();
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);
    step(3'd4, 2'd1, 1'b0, 2'd0, 1'b0);          // cycle c
    check("R4 pre legal", cmd_legal, 1'b1);
    nop();                                         // c+1
    check("R4 row closed", row_open, 4'b0000);
    check("R4 busy c+1", bank_busy, 4'b0010);
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);          // c+2
    check("R4 act while busy", cmd_legal, 1'b0);
    nop();                                         // c+3
    check("R4 busy c+TRP", bank_busy, 4'b0010);
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);          // c+4
    check("R4 idle after TRP", bank_busy, 4'b0000);
    check("R4 act after TRP", cmd_legal, 1'b1);
    step(3'd4, 2'd3, 1'b0, 2'd0, 1'b0);
    check("R4 pre closed bank legal", cmd_legal, 1'b1);
    nop();
    check("R4 pre closed bank no busy", bank_busy, 4'b0000);
    check("R4 pre closed bank rows", row_open, 4'b0010);
  endtask

  task automatic t_autopre();
    do_reset();
    step(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);
    step(3'd1, 2'd3, 1'b0, 2'd0, 1'b0);
    step(3'd2, 2'd0, 1'b1, 2'd2, 1'b0);          // c: read, ap, length 4
    check("R5 ap read legal", cmd_legal, 1'b1);
    step(3'd3, 2'd3, 1'b0, 2'd0, 1'b0);          // c+1
    check("R9 write during ap burst", cmd_legal, 1'b0);
    check("R5 busy c+1", bank_busy, 4'b0001);
    check("R5 open c+1", row_open, 4'b1001);
    step(3'd5, 2'd0, 1'b0, 2'd0, 1'b0);          // c+2
    check("R9 bst during ap burst", cmd_legal, 1'b0);
    step(3'd1, 2'd2, 1'b0, 2'd0, 1'b0);          // c+3
    check("R9 act other bank", cmd_legal, 1'b1);
    check("R5 open at last beat", row_open, 4'b1001);
    step(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);          // c+4
    check("R5 row closed c+N", row_open, 4'b1100);
    check("R5 busy c+N", bank_busy, 4'b0001);
    check("R5 act during tRP", cmd_legal, 1'b0);
    nop(); nop(); nop();                           // c+5..c+7
    check("R5 busy c+N+TRP", bank_busy, 4'b0001);
    step(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);          // c+8
    check("R5 idle c+N+TRP+1", bank_busy, 4'b0000);
    check("R5 act after window", cmd_legal, 1'b1);
    step(3'd2, 2'd0, 1'b0, 2'd0, 1'b0);          // c+9
    check("R7 plain read legal", cmd_legal, 1'b1);
    nop(); nop(); nop();
    check("R7 ap not sticky open", row_open, 4'b1101);
    check("R7 ap not sticky idle", bank_busy, 4'b0000);
  endtask

  task automatic t_ap_bl1();
    do_reset();
    step(3'd1, 2'd2, 1'b0, 2'd0, 1'b0);
    step(3'd2, 2'd2, 1'b1, 2'd0, 1'b0);          // c
    nop();                                         // c+1
    check("R5 bl1 row closed", row_open, 4'b0000);
    check("R5 bl1 busy", bank_busy, 4'b0100);
    nop(); nop();                                  // c+2, c+3
    step(3'd1, 2'd2, 1'b0, 2'd0, 1'b0);          // c+4
    check("R5 bl1 busy end", bank_busy, 4'b0100);
    check("R5 bl1 act blocked", cmd_legal, 1'b0);
    step(3'd1, 2'd2, 1'b0, 2'd0, 1'b0);          // c+5
    check("R5 bl1 act free", cmd_legal, 1'b1);
  endtask

  task automatic t_fullpage();
    do_reset();
    step(3'd1, 2'd3, 1'b0, 2'd0, 1'b0);
    step(3'd2, 2'd3, 1'b1, 2'd0, 1'b1);
    check("R6 full page ap read legal", cmd_legal, 1'b1);
    for (int i = 0; i < 10; i++) nop();
    check("R6 row open", row_open, 4'b1000);
    check("R6 bank idle", bank_busy, 4'b0000);
    step(3'd2, 2'd3, 1'b0, 2'd1, 1'b0);
    check("R6 read allowed after", cmd_legal, 1'b1);
    step(3'd5, 2'd0, 1'b0, 2'd0, 1'b0);
    check("R8 bst legal", cmd_legal, 1'b1);
    nop();
    check("R8 bst keeps row", row_open, 4'b1000);
  endtask

  task automatic t_bst();
    do_reset();
    step(3'd5, 2'd2, 1'b0, 2'd0, 1'b0);
    check("R8 bst no burst legal", cmd_legal, 1'b1);
    nop();
    check("R8 bst alone rows", row_open, 4'b0000);
    check("R8 bst alone busy", bank_busy, 4'b0000);
    step(3'd1, 2'd1, 1'b0, 2'd0, 1'b0);
    step(3'd2, 2'd1, 1'b0, 2'd3, 1'b0);
    step(3'd5, 2'd1, 1'b0, 2'd0, 1'b0);
    check("R8 bst fixed burst legal", cmd_legal, 1'b1);
    nop(); nop();
    check("R8 fixed burst row open", row_open, 4'b0010);
  endtask

  task automatic t_undefined();
    do_reset();
    step(3'd1, 2'd0, 1'b0, 2'd0, 1'b0);
    step(3'd6, 2'd0, 1'b0, 2'd0, 1'b0);
    check("R10 code 6 illegal", cmd_legal, 1'b0);
    step(3'd7, 2'd0, 1'b1, 2'd0, 1'b0);
    check("R10 code 7 illegal", cmd_legal, 1'b0);
    nop();
    check("R10 undefined rows", row_open, 4'b0001);
    check("R10 undefined busy", bank_busy, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_code = 3'd0; cmd_bank = 2'd0; cmd_ap = 1'b0; burst_code = 2'd0; burst_full = 1'b0;
    t_reset();
    t_activate();
    t_rw();
    t_precharge();
    t_autopre();
    t_ap_bl1();
    t_fullpage();
    t_bst();
    t_undefined();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule